// File: doc/BRIEF.md
# Chip Select Wait-State Terminator

This block ends bus accesses that fall inside one chip-select address window. An access begins when a one-cycle start strobe arrives together with a flag that says the address hit this window. A small down-counter then measures out a programmable number of wait states, from zero to the largest value the field can hold. When the count runs out, the block raises a one-cycle termination strobe. With zero wait states, the strobe comes in the cycle right after the start. With N wait states, it comes N+1 cycles after the start.

A per-window enable chooses the source of termination. When it is set, the internal timer ends the access, and an external acknowledge can still end it sooner. When it is clear, the block never times out on its own, and the access lasts until the external acknowledge arrives. Read and write accesses can use separate wait-state counts. The block latches its configuration when the access starts, so software may change the configuration bits while an access is in flight without disturbing it.

Top module: `cs_wait_term`

## Requirements
- R1: With the auto-termination enable at 1 and a selected wait-state count of 0, `term_o` is high in the cycle right after the cycle in which `cyc_start` and `cs_hit` are both high.
- R2: The wait-state fields are plain binary (000 = 0 through 111 = 7 at the default 3-bit width). With auto-termination enabled and a count of N, `term_o` is high exactly N+1 cycles after the start cycle.
- R3: When `cfg_wr_sep` = 1 and `wr` = 1 at the start, the count comes from `cfg_wr_ws`. In every other case it comes from `cfg_ws`.
- R4: With auto-termination disabled (`cfg_auto_en` = 0), the block never ends an access on its own. `term_o` is high in the first cycle after the start in which `ext_ack` is high.
- R5: With auto-termination enabled, an `ext_ack` in cycle k+d, where 1 ≤ d ≤ N, drives `term_o` high in that same cycle. No internal strobe follows it.
- R6: Each access gives exactly one termination pulse. An `ext_ack` in the cycle where the internal count expires gives one pulse. An `ext_ack` after the access has ended is ignored.
- R7: A `cyc_start` with `cs_hit` = 0 starts no access and produces no termination, and `ext_ack` while idle is ignored.
- R8: The configuration inputs and `wr` are sampled only in the start cycle. Changing them later does not alter the timing of that access.
- R9: A `cyc_start` during an active access is ignored and does not restart the count.
- R10: A synchronous active-high `rst` returns the block to idle with `term_o` low, and it abandons any access in flight.
- R11: A new start is accepted in the very cycle in which an internally timed access terminates, so accesses can run back to back. A start in the cycle where an external acknowledge ends an access is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-cycle access start strobe |
| cs_hit | input | 1 | Access address falls in this window |
| wr | input | 1 | Direction: 1 = write, 0 = read |
| cfg_ws | input | WS_W | Wait-state count (reads, or all accesses) |
| cfg_wr_ws | input | WS_W | Wait-state count for writes |
| cfg_wr_sep | input | 1 | 1 = writes use `cfg_wr_ws` |
| cfg_auto_en | input | 1 | 1 = internal timer ends accesses |
| ext_ack | input | 1 | External acknowledge, ends an active access |
| term_o | output | 1 | One-cycle access termination strobe |

## Verification
The assertions check the following on every cycle:
- a zero count fires on the next cycle;
- the counter steps down by one and never sits at zero while counting;
- an external-only access never fires internally;
- an early acknowledge clears the timer without a later pulse;
- a miss leaves the block idle;
- a start during an access does not disturb it;
- the internal strobe never overlaps an open access.

Only the bench scenarios can show the end-to-end timing. These cover:
- the exact N+1 cycle count for every code;
- the choice between the read and write fields;
- the immunity to configuration changes after the start;
- back-to-back starts in the termination cycle;
- abandonment of an access by reset.

// File: rtl/cs_wait_pkg.sv
package cs_wait_pkg;

   // largest supported wait-state field width
   localparam int WS_W_MAX = 6;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_TIMED = 2'd1,
      ST_EXT   = 2'd2
   } acc_state_e;

endpackage

// File: rtl/cs_wait_sel.sv
module cs_wait_sel #(
   parameter int WS_W         = 3,
   parameter bit HAS_WR_FIELD = 1'b1
) (
   input  logic            wr,
   input  logic            wr_sep,
   input  logic [WS_W-1:0] ws_rd,
   input  logic [WS_W-1:0] ws_wr,
   output logic [WS_W-1:0] ws_sel
);

   generate
      if (HAS_WR_FIELD) begin : g_split
         // separate write count only when enabled and the access writes
         assign ws_sel = (wr_sep && wr) ? ws_wr : ws_rd;
      end else begin : g_shared
         logic unused_sel;
         assign unused_sel = ^{wr, wr_sep, ws_wr};
         assign ws_sel     = ws_rd;
      end
   endgenerate

endmodule

// File: rtl/cs_wait_timer.sv
module cs_wait_timer
   import cs_wait_pkg::*;
#(
   parameter int WS_W = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start,
   input  logic            hit,
   input  logic            auto_en,
   input  logic [WS_W-1:0] ws,
   input  logic            ext_ack,
   output logic            fire_q,
   output logic            active
);

   localparam logic [WS_W-1:0] ONE  = WS_W'(1);
   localparam logic [WS_W-1:0] ZERO = '0;

   acc_state_e      state_q, state_d;
   logic [WS_W-1:0] cnt_q, cnt_d;
   logic            fire_d;
   logic            take;

   assign take   = start && hit && (state_q == ST_IDLE);
   assign active = (state_q != ST_IDLE);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      fire_d  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (take) begin
               if (!auto_en) begin
                  state_d = ST_EXT;
               end else if (ws == ZERO) begin
                  fire_d = 1'b1;
               end else begin
                  state_d = ST_TIMED;
                  cnt_d   = ws;
               end
            end
         end
         ST_TIMED: begin
            if (ext_ack) begin
               state_d = ST_IDLE;
               cnt_d   = ZERO;
            end else if (cnt_q == ONE) begin
               state_d = ST_IDLE;
               cnt_d   = ZERO;
               fire_d  = 1'b1;
            end else begin
               cnt_d = cnt_q - ONE;
            end
         end
         ST_EXT: begin
            if (ext_ack) begin
               state_d = ST_IDLE;
            end
         end
         default: begin
            state_d = ST_IDLE;
            cnt_d   = ZERO;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         cnt_q   <= ZERO;
         fire_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         fire_q  <= fire_d;
      end
   end

   // R1
   zero_wait_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_IDLE && start && hit && auto_en && ws == ZERO) |=> fire_q);

   // R2
   cnt_live_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_TIMED) |-> (cnt_q != ZERO));

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_TIMED && !ext_ack && cnt_q != ONE)
      |=> (state_q == ST_TIMED && cnt_q == $past(cnt_q) - ONE));

   // R4
   ext_only_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_EXT) |=> !fire_q);

   // R5
   early_cut_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_TIMED && ext_ack) |=> (state_q == ST_IDLE && !fire_q));

   // R7
   miss_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_IDLE && !(start && hit)) |=> (state_q == ST_IDLE && !fire_q));

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_EXT && !ext_ack) |=> (state_q == ST_EXT));

endmodule

// File: rtl/cs_wait_merge.sv
module cs_wait_merge (
   input  logic clk,
   input  logic rst,
   input  logic fire_q,
   input  logic active,
   input  logic ext_ack,
   output logic term
);

   // external acknowledge only counts while an access is open
   assign term = fire_q || (active && ext_ack);

   // R6
   one_src_chk: assert property (@(posedge clk) disable iff (rst)
      fire_q |-> !active);

endmodule

// File: rtl/cs_wait_term.sv
module cs_wait_term
   import cs_wait_pkg::*;
#(
   parameter int WS_W         = 3,
   parameter bit HAS_WR_FIELD = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            cyc_start,
   input  logic            cs_hit,
   input  logic            wr,
   input  logic [WS_W-1:0] cfg_ws,
   input  logic [WS_W-1:0] cfg_wr_ws,
   input  logic            cfg_wr_sep,
   input  logic            cfg_auto_en,
   input  logic            ext_ack,
   output logic            term_o
);

   generate
      if (WS_W < 1 || WS_W > WS_W_MAX) begin : g_bad_width
         $error("cs_wait_term: WS_W out of supported range");
      end
   endgenerate

   logic [WS_W-1:0] ws_sel;
   logic            fire_q;
   logic            active;

   cs_wait_sel #(
      .WS_W         (WS_W),
      .HAS_WR_FIELD (HAS_WR_FIELD)
   ) u_sel (
      .wr     (wr),
      .wr_sep (cfg_wr_sep),
      .ws_rd  (cfg_ws),
      .ws_wr  (cfg_wr_ws),
      .ws_sel (ws_sel)
   );

   cs_wait_timer #(
      .WS_W (WS_W)
   ) u_timer (
      .clk     (clk),
      .rst     (rst),
      .start   (cyc_start),
      .hit     (cs_hit),
      .auto_en (cfg_auto_en),
      .ws      (ws_sel),
      .ext_ack (ext_ack),
      .fire_q  (fire_q),
      .active  (active)
   );

   cs_wait_merge u_merge (
      .clk     (clk),
      .rst     (rst),
      .fire_q  (fire_q),
      .active  (active),
      .ext_ack (ext_ack),
      .term    (term_o)
   );

endmodule

// File: tb/sim_cs_wait_term.sv
`timescale 1ns/1ps
module sim_cs_wait_term;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cyc_start = 1'b0;
   logic       cs_hit = 1'b0;
   logic       wr = 1'b0;
   logic [2:0] cfg_ws = '0;
   logic [2:0] cfg_wr_ws = '0;
   logic       cfg_wr_sep = 1'b0;
   logic       cfg_auto_en = 1'b0;
   logic       ext_ack = 1'b0;
   logic       term_o;

   int    cyc = 0;
   int    total = 0;
   int    bad = 0;
   int    seen = 0;
   string cur_tag = "R10";
   int    q_cyc[$];
   string q_tag[$];
   bit    done = 1'b0;

   always #5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   cs_wait_term u0 (
      .clk         (clk),
      .rst         (rst),
      .cyc_start   (cyc_start),
      .cs_hit      (cs_hit),
      .wr          (wr),
      .cfg_ws      (cfg_ws),
      .cfg_wr_ws   (cfg_wr_ws),
      .cfg_wr_sep  (cfg_wr_sep),
      .cfg_auto_en (cfg_auto_en),
      .ext_ack     (ext_ack),
      .term_o      (term_o)
   );

   // monitor: pops expected termination cycles and compares
   always @(negedge clk) begin
      if (!rst) begin
         if (term_o) begin
            seen = seen + 1;
            total = total + 1;
            if (q_cyc.size() == 0) begin
               bad = bad + 1;
               $display("FAIL %s: unexpected termination at cycle %0d (actual term=1 expected term=0)",
                        cur_tag, cyc);
            end else begin
               int    c;
               string t;
               c = q_cyc.pop_front();
               t = q_tag.pop_front();
               if (c != cyc) begin
                  bad = bad + 1;
                  $display("FAIL %s: termination at cycle %0d expected %0d", t, cyc, c);
               end
            end
         end else if (q_cyc.size() > 0 && cyc > q_cyc[0]) begin
            int    c;
            string t;
            c = q_cyc.pop_front();
            t = q_tag.pop_front();
            total = total + 1;
            bad = bad + 1;
            $display("FAIL %s: no termination by cycle %0d (actual none expected %0d)", t, cyc, c);
         end
      end
   end

   // driver: one access; ack_d = cycle offset of ext_ack (0 = none)
   task automatic access(input int ws, input bit w, input bit sep, input int wws,
                         input bit auto, input bit hit, input int ack_d,
                         input bit restart_mid, input bit b2b, input string tag);
      int k, n, e, lim, s0;
      @(posedge clk); #1;
      k = cyc;
      s0 = seen;
      cur_tag = tag;
      cyc_start = 1'b1; cs_hit = hit; wr = w;
      cfg_ws = 3'(ws); cfg_wr_ws = 3'(wws); cfg_wr_sep = sep; cfg_auto_en = auto;
      ext_ack = 1'b0;
      n = (sep && w) ? wws : ws;
      if (!hit) e = -1;
      else if (auto) e = (ack_d > 0 && ack_d <= n) ? k + ack_d : k + n + 1;
      else e = (ack_d > 0) ? k + ack_d : -1;
      if (e >= 0) begin
         q_cyc.push_back(e);
         q_tag.push_back(tag);
      end
      if (e < 0) lim = 10;
      else if (b2b) lim = e - k - 1;
      else lim = ((ack_d > e - k) ? ack_d : e - k) + 2;
      for (int j = 1; j <= lim; j++) begin
         @(posedge clk); #1;
         cyc_start = restart_mid && (j == 1);
         cs_hit = restart_mid && (j == 1);
         wr = ~w; cfg_ws = ~3'(ws); cfg_wr_ws = ~3'(wws);
         cfg_wr_sep = ~sep; cfg_auto_en = ~auto;
         ext_ack = (ack_d == j);
      end
      if (e < 0) begin
         total = total + 1;
         if (seen != s0) begin
            bad = bad + 1;
            $display("FAIL %s: terminations during ignored start actual %0d expected 0", tag, seen - s0);
         end
      end
      if (!b2b) begin
         cyc_start = 1'b0; cs_hit = 1'b0; ext_ack = 1'b0;
      end
   endtask

   initial begin
      // R10 reset state
      repeat (3) @(negedge clk);
      total = total + 1;
      if (term_o !== 1'b0) begin
         bad = bad + 1;
         $display("FAIL R10: term during reset actual %b expected 0", term_o);
      end
      @(posedge clk); #1; rst = 1'b0;
      repeat (2) @(posedge clk);

      // R1, R2: every wait-state code, reads, internal termination
      for (int i = 0; i < 8; i++) access(i, 0, 0, 0, 1, 1, 0, 0, 0, (i == 0) ? "R1" : "R2");

      // R3: direction selects the field
      access(2, 1, 1, 5, 1, 1, 0, 0, 0, "R3");
      access(2, 0, 1, 5, 1, 1, 0, 0, 0, "R3");
      access(2, 1, 0, 5, 1, 1, 0, 0, 0, "R3");
      access(6, 1, 1, 0, 1, 1, 0, 0, 0, "R3");

      // R4: external-only termination
      access(0, 0, 0, 0, 0, 1, 4, 0, 0, "R4");
      access(3, 0, 0, 0, 0, 1, 1, 0, 0, "R4");
      access(1, 1, 1, 1, 0, 1, 9, 0, 0, "R4");

      // R5: early external acknowledge
      access(6, 0, 0, 0, 1, 1, 3, 0, 0, "R5");
      access(7, 0, 0, 0, 1, 1, 1, 0, 0, "R5");

      // R6: coincident and late acknowledge
      access(3, 0, 0, 0, 1, 1, 4, 0, 0, "R6");
      access(2, 0, 0, 0, 1, 1, 6, 0, 0, "R6");

      // R7: miss, with an acknowledge while idle
      access(1, 0, 0, 0, 1, 0, 3, 0, 0, "R7");
      access(0, 0, 0, 0, 1, 0, 0, 0, 0, "R7");

      // R8: config scrambled after start in every access; explicit case
      access(5, 1, 1, 4, 1, 1, 0, 0, 0, "R8");

      // R9: start during an active access
      access(0, 0, 0, 0, 0, 1, 5, 1, 0, "R9");
      access(4, 0, 0, 0, 1, 1, 0, 1, 0, "R9");

      // R11: back-to-back starts in the termination cycle
      access(0, 0, 0, 0, 1, 1, 0, 0, 1, "R11");
      access(2, 0, 0, 0, 1, 1, 0, 0, 1, "R11");
      access(1, 0, 0, 0, 1, 1, 0, 0, 0, "R11");

      // R10: reset abandons an access in flight
      begin
         int s0;
         s0 = seen;
         cur_tag = "R10";
         @(posedge clk); #1;
         cyc_start = 1'b1; cs_hit = 1'b1; cfg_auto_en = 1'b1; cfg_ws = 3'd6;
         cfg_wr_sep = 1'b0; wr = 1'b0;
         @(posedge clk); #1; cyc_start = 1'b0; cs_hit = 1'b0;
         @(posedge clk); #1; rst = 1'b1;
         @(posedge clk); #1; rst = 1'b0;
         repeat (12) @(posedge clk);
         #1;
         total = total + 1;
         if (seen != s0) begin
            bad = bad + 1;
            $display("FAIL R10: terminations after reset actual %0d expected 0", seen - s0);
         end
      end

      // nothing left outstanding
      total = total + 1;
      if (q_cyc.size() != 0) begin
         bad = bad + 1;
         $display("FAIL R6: outstanding expectations actual %0d expected 0", q_cyc.size());
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         total = total + 1;
         bad = bad + 1;
         $display("FAIL R2: watchdog expired actual hung expected finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule